// File: doc/BRIEF.md
# Modem Line Control and Status Register

This block holds the modem-control byte and the modem-status byte of a classic asynchronous serial port. The control byte drives four outward handshake lines (request-to-send, data-terminal-ready and two general-purpose auxiliary outputs) and holds a loop-test enable. The status byte reports the present level of four inward handshake lines (clear-to-send, data-set-ready, ring, carrier-detect) in its upper nibble. Its lower nibble holds sticky change flags that record every level change since the host last read the status byte.

The inward lines are asynchronous. Each passes through a synchronizer before change detection. In loop-test mode the four control bits are fed back as the status levels and the external inward lines are ignored. The two handshake outputs are then held inactive. A single summary flag, the OR of the change flags, goes to the interrupt logic of the surrounding port.

The host side is plain register access with no back-pressure. A write strobe is accepted on every cycle it is high. The read data is combinational from the selected register. A read strobe with the status byte selected clears the change flags at the clock edge on which it is sampled. No data stream passes through the block, so it has no valid/ready interface.

Top module: `modem_ctl_status`

## Requirements
- R1: Status byte bits 7:4 hold the levels carrier-detect (bit 7), ring (bit 6), data-set-ready (bit 5) and clear-to-send (bit 4). A pin change set up before rising edge k appears after edge k+2, through two synchronizer stages and one level register.
- R2: A level change on clear-to-send, data-set-ready or carrier-detect sets status bit 0, 1 or 3 respectively. The bit stays set until the status byte is read.
- R3: Status bit 2 is set only when the ring level falls from 1 to 0. A rising ring level sets no flag.
- R4: A cycle with rd_en=1 and rd_sel=1 clears bits 3:0 at that edge. A change detected at the same edge still sets its flag.
- R5: While control bit 4 is 1, the status levels come from the control byte: bit 3 to carrier-detect, bit 2 to ring, bit 1 to clear-to-send and bit 0 to data-set-ready. The external lines then affect neither the levels nor the flags. Entering or leaving this mode sets flags for any levels that differ.
- R6: A write stores wr_data bits 4:0 in the control byte, and bits 7:5 read as 0. With rd_sel=0, rd_data shows the control byte. It is readable in the cycle after the write.
- R7: drv_dtr follows control bit 0 and drv_rts follows control bit 1, both forced to 0 while bit 4 is 1. drv_aux1 and drv_aux2 follow bits 2 and 3 in every mode.
- R8: status_change is 1 exactly when any of status bits 3:0 is 1.
- R9: After reset the control byte is 0x08, the status byte is 0xB0 and status_change is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| rd_en | input | 1 | Read strobe; clears the change flags when rd_sel=1 |
| rd_sel | input | 1 | 0 selects the control byte, 1 the status byte |
| rd_data | output | 8 | Selected register value |
| line_cts | input | 1 | Clear-to-send input, asynchronous |
| line_dsr | input | 1 | Data-set-ready input, asynchronous |
| line_ri | input | 1 | Ring input, asynchronous |
| line_dcd | input | 1 | Carrier-detect input, asynchronous |
| drv_rts | output | 1 | Request-to-send output |
| drv_dtr | output | 1 | Data-terminal-ready output |
| drv_aux1 | output | 1 | Auxiliary output 1 |
| drv_aux2 | output | 1 | Auxiliary output 2 |
| status_change | output | 1 | OR of the change flags, to the interrupt logic |

## Verification
A corrupt level register shows in bits 7:4 of the status read on the next cycle. It also sets a spurious change flag at the following edge, which raises status_change within one clock. A lost or sticky flag shows as a wrong lower nibble or a wrong status_change value one cycle after the pin change or read strobe that should have set or cleared it. The bench model therefore compares every port on every cycle, so a fault shows up no later than one clock after the event that exposes it. A wrong loop mapping changes the levels one edge after the control write, and every write pattern in loop mode is checked.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int LINE_W = 4;
  localparam int REG_W  = 8;

  typedef logic [LINE_W-1:0] line_vec_t;

  // line vector index = change-flag bit = level bit - LINE_W
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  // control byte fields
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_AUX1 = 2;
  localparam int C_AUX2 = 3;
  localparam int C_LOOP = 4;

  localparam logic [REG_W-1:0] CTL_MASK = 8'h1F;
  localparam logic [REG_W-1:0] CTL_RST  = 8'h08;
  localparam line_vec_t        LVL_RST  = 4'b1011;  // dcd, dsr, cts high

  // loop-test feedback of control bits onto the status lines
  function automatic line_vec_t loop_map(input logic [REG_W-1:0] c);
    line_vec_t v;
    v[L_DCD] = c[C_AUX2];
    v[L_RI]  = c[C_AUX1];
    v[L_CTS] = c[C_RTS];
    v[L_DSR] = c[C_DTR];
    return v;
  endfunction
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= RST_VAL;
          else        r <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= RST_VAL;
          else        r <= g_stage[s-1].r;
        end
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
  import modem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctl,
  output logic             loop_on,
  output logic             o_rts,
  output logic             o_dtr,
  output logic             o_aux1,
  output logic             o_aux2
);
  logic [REG_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= CTL_RST;
    else if (wr_en) ctl_q <= wr_data & CTL_MASK;
  end

  assign ctl     = ctl_q;
  assign loop_on = ctl_q[C_LOOP];
  // handshake outputs parked inactive during loop test
  assign o_dtr   = ctl_q[C_DTR] & ~ctl_q[C_LOOP];
  assign o_rts   = ctl_q[C_RTS] & ~ctl_q[C_LOOP];
  assign o_aux1  = ctl_q[C_AUX1];
  assign o_aux2  = ctl_q[C_AUX2];
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import modem_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t src,
  input  logic      clr,
  output line_vec_t levels,
  output line_vec_t deltas
);
  line_vec_t lvl_q, dlt_q, evt;

  generate
    for (genvar i = 0; i < LINE_W; i++) begin : g_evt
      if (i == L_RI) begin : g_trail
        assign evt[i] = lvl_q[i] & ~src[i];
      end else begin : g_any
        assign evt[i] = lvl_q[i] ^ src[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_RST;
      dlt_q <= '0;
    end else begin
      lvl_q <= src;
      dlt_q <= (clr ? '0 : dlt_q) | evt;
    end
  end

  assign levels = lvl_q;
  assign deltas = dlt_q;
endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  input  logic       line_cts,
  input  logic       line_dsr,
  input  logic       line_ri,
  input  logic       line_dcd,
  output logic       drv_rts,
  output logic       drv_dtr,
  output logic       drv_aux1,
  output logic       drv_aux2,
  output logic       status_change
);
  line_vec_t        pins, pins_s, src, lvl, dlt;
  logic [REG_W-1:0] mcr_q, msr_q;
  logic             loop_on;

  assign pins[L_CTS] = line_cts;
  assign pins[L_DSR] = line_dsr;
  assign pins[L_RI]  = line_ri;
  assign pins[L_DCD] = line_dcd;

  modem_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(LVL_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pins_s)
  );

  modem_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctl(mcr_q), .loop_on(loop_on),
    .o_rts(drv_rts), .o_dtr(drv_dtr), .o_aux1(drv_aux1), .o_aux2(drv_aux2)
  );

  assign src = loop_on ? loop_map(mcr_q) : pins_s;

  modem_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .src(src), .clr(rd_en & rd_sel),
    .levels(lvl), .deltas(dlt)
  );

  assign msr_q         = {lvl, dlt};
  assign rd_data       = rd_sel ? msr_q : mcr_q;
  assign status_change = |dlt;
endmodule

// File: rtl/modem_ctl_status_chk.sv
module modem_ctl_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic       rd_sel,
  input logic [7:0] mcr_q,
  input logic [7:0] msr_q,
  input logic       drv_rts,
  input logic       drv_dtr,
  input logic       status_change
);
  // flags never drop without a status read
  p_flags_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_sel) |=> ((msr_q[3:0] & $past(msr_q[3:0])) == $past(msr_q[3:0])));

  p_ring_trailing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr_q[2]) |-> (!msr_q[6] && $past(msr_q[6])));

  p_loop_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_q[4] |=> (msr_q[7:4] == {$past(mcr_q[3]), $past(mcr_q[2]), $past(mcr_q[0]), $past(mcr_q[1])}));

  p_ctl_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mcr_q == ($past(wr_data) & 8'h1F)));

  p_loop_parks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4]) |=> (!drv_rts && !drv_dtr));

  p_change_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_change) |-> (msr_q[7:4] != $past(msr_q[7:4])));
endmodule

bind modem_ctl_status modem_ctl_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_sel(rd_sel), .mcr_q(mcr_q), .msr_q(msr_q),
  .drv_rts(drv_rts), .drv_dtr(drv_dtr), .status_change(status_change)
);

// File: tb/modem_ctl_status_test.sv
module modem_ctl_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic       rd_sel = 1'b1;
  logic [7:0] rd_data;
  logic       line_cts = 1'b1, line_dsr = 1'b1, line_ri = 1'b0, line_dcd = 1'b1;
  logic       drv_rts, drv_dtr, drv_aux1, drv_aux2, status_change;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  modem_ctl_status uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .line_cts(line_cts), .line_dsr(line_dsr), .line_ri(line_ri), .line_dcd(line_dcd),
    .drv_rts(drv_rts), .drv_dtr(drv_dtr), .drv_aux1(drv_aux1), .drv_aux2(drv_aux2),
    .status_change(status_change)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // reference model; line index 0 cts, 1 dsr, 2 ri, 3 dcd
  logic [7:0] m_ctl = 8'h08;
  logic [3:0] m_lvl = 4'b1011, m_dlt = 4'h0, m_p1 = 4'b1011, m_p2 = 4'b1011;
  logic       m_rd_prev = 1'b0;

  always @(posedge clk) begin
    logic [3:0] src, ev;
    if (!rst_n) begin
      m_ctl = 8'h08; m_lvl = 4'b1011; m_dlt = 4'h0;
      m_p1 = 4'b1011; m_p2 = 4'b1011; m_rd_prev = 1'b0;
    end else begin
      src = m_ctl[4] ? {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]} : m_p2;
      ev = (src ^ m_lvl) & 4'b1011;
      ev[2] = m_lvl[2] & ~src[2];
      m_dlt = ((rd_en && rd_sel) ? 4'h0 : m_dlt) | ev;
      m_rd_prev = rd_en && rd_sel;
      m_lvl = src;
      m_p2 = m_p1;
      m_p1 = {line_dcd, line_ri, line_dsr, line_cts};
      if (wr_en) m_ctl = wr_data & 8'h1F;
    end
    #2;
    if (!rst_n) begin
      chk("R9 status after reset", uut.rd_sel ? rd_data : 8'hB0, 8'hB0);
      chk("R9 change flag after reset", {7'd0, status_change}, 8'h00);
    end else if (rd_sel) begin
      chk(m_ctl[4] ? "R5 loop levels" : "R1 line levels", {4'h0, rd_data[7:4]}, {4'h0, m_lvl});
      chk("R3 ring trailing flag", {7'd0, rd_data[2]}, {7'd0, m_dlt[2]});
      chk(m_rd_prev ? "R4 flags after read" : "R2 change flags",
          {4'h0, rd_data[3], 1'b0, rd_data[1:0]}, {4'h0, m_dlt[3], 1'b0, m_dlt[1:0]});
    end else begin
      chk("R6 control byte", rd_data, m_ctl);
    end
    if (rst_n) begin
      chk("R7 outputs", {4'h0, drv_aux2, drv_aux1, drv_rts, drv_dtr},
          {4'h0, m_ctl[3], m_ctl[2], m_ctl[1] & ~m_ctl[4], m_ctl[0] & ~m_ctl[4]});
      chk("R8 summary flag", {7'd0, status_change}, {7'd0, |m_dlt});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel);
    @(negedge clk); rd_sel = sel; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; rd_sel = 1'b1;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    rd(1'b0);                                   // R9 control reset value
    // R1/R2: single line changes
    @(negedge clk); line_cts = 1'b0; idle(6);
    @(negedge clk); line_dsr = 1'b0; idle(6);
    @(negedge clk); line_dcd = 1'b0; idle(6);
    rd(1'b1); idle(3);
    // R3: ring rise sets nothing, fall sets flag
    @(negedge clk); line_ri = 1'b1; idle(6);
    @(negedge clk); line_ri = 1'b0; idle(6);
    rd(1'b1); idle(3);
    // R4: read in the same edge as a new change
    @(negedge clk); line_cts = 1'b1; idle(1);
    rd(1'b1); idle(4);
    rd(1'b1); idle(2);
    // R6/R7: write with upper bits, then handshake patterns
    wr(8'hE3); rd(1'b0); idle(2);
    wr(8'h0C); rd(1'b0); idle(2);
    // R5: loop test, external lines ignored
    wr(8'h1F); idle(3);
    @(negedge clk); line_cts = 1'b0; line_ri = 1'b1; line_dcd = 1'b1; idle(5);
    wr(8'h10); idle(3);
    wr(8'h15); idle(3);
    wr(8'h1A); idle(3);
    rd(1'b1); idle(3);
    wr(8'h03); idle(6);
    rd(1'b1); idle(2);
    // mixed traffic
    for (int i = 0; i < 150; i++) begin
      logic [7:0] h;
      h = 8'(i * 37 + (i >> 2) * 11);
      @(negedge clk);
      {line_dcd, line_ri, line_dsr, line_cts} = h[3:0] ^ h[7:4];
      wr_en   = (i % 9) == 4;
      wr_data = h ^ 8'h5A;
      rd_en   = (i % 5) == 2;
      rd_sel  = (i % 7) != 3;
    end
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; rd_sel = 1'b1;
    idle(8);
    finish_run();
  end
endmodule